// File: doc/BRIEF.md
# Governed Predicate Logic Unit

This block applies one bitwise logical operation to two predicate registers, a first operand A and a second operand B, under a governing predicate G. It writes the result to a destination predicate register. A predicate holds one bit per lane, and its length in bits is a parameter. The block walks the registers one 64-bit word per clock. It drives the word index and the register selects toward an external register file. The file answers reads in the same cycle, and the block writes the result word back in that same cycle.

The operation comes from a 32-bit instruction word, which is presented together with a one-cycle `start` pulse. Eight operations exist. Seven of them force every lane where G is clear to zero. The eighth, a lane select, takes A where G is set and B where G is clear. Some encodings also update a set of condition flags from the result: first-active, none-active, not-last-active and an always-clear overflow flag. An encoding that is malformed or not defined raises `illegal` and touches nothing.

When the length is not a multiple of 64, the final word of G is trimmed to its valid low bits. The trim happens before the operation and before flag evaluation.

Top module: `predlogic_unit`

## Requirements
- R1: For ops AND, BIC, ORR, ORN, EOR, NOR and NAND, each result lane is respectively A&B, A&~B, A|B, A|~B, A^B, ~(A|B) or ~(A&B), ANDed with the G lane. Inactive lanes therefore read 0.
- R2: The select op gives A where G is 1 and B where G is 0, so inactive lanes are not zeroed.
- R3: The instruction fields are as follows. The fixed bits are [31:24]=8'h25, [21:20]=2'b00 and [15:14]=2'b01. The destination is [3:0], A is [8:5], G is [13:10] and B is [19:16]. Bit 23 picks the family: 0 gives AND, BIC, EOR, SEL and 1 gives ORR, ORN, NOR, NAND. Within the family, {bit9,bit4} = 00,01,10,11 picks the ops in that order. Bit 22 set requests a flag update.
- R4: An encoding is illegal if any fixed bit is wrong, or if it requests a flag update with the select op (bit23=0, bit22=1, {bit9,bit4}=11). On such an encoding, `illegal` pulses for one cycle, the cycle after `start`. No write occurs, `busy` and `done` stay low, and the flags keep their value.
- R5: An accepted op holds `busy` for exactly ceil(LEN/64) cycles and writes words 0 upward, one per cycle. `done` then pulses for one cycle, the cycle after the last write. A `start` raised while `busy` is ignored.
- R6: A flag-setting op sets the outputs as follows, all of them together with `done`:
  - `flag_n` is the result bit at the lowest set bit of G.
  - `flag_z` is 1 when no result bit within the length is set.
  - `flag_c` is the inverse of the result bit at the highest set bit of G.
  - `flag_v` is 0.
- R7: With G all zero, a flag-setting op gives flag_n=0, flag_z=1 and flag_c=1.
- R8: An op without flag update leaves all four flag outputs unchanged.
- R9: The trim works as follows.
  - When LEN is not a multiple of 64, G bits at and above LEN are treated as 0 for the result and for the flags.
  - For the zeroing ops, the destination bits at and above LEN are 0.
  - The last-active lane is found within LEN.
- R10: Each result word is written in the same cycle its operand words are read. The destination may therefore be the same register as A, B or G and still give the unaliased result.
- R11: After reset, `busy`, `done`, `illegal`, `wr_en` and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request; `insn` is sampled with it |
| insn | input | 32 | Instruction word |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | One-cycle pulse for an undefined encoding |
| rf_word | output | IDX_W | Word index for reads and write |
| rf_a_sel | output | 4 | Register select of operand A |
| rf_b_sel | output | 4 | Register select of operand B |
| rf_g_sel | output | 4 | Register select of the governing predicate |
| rf_a_data | input | 64 | Word of A at `rf_word` |
| rf_b_data | input | 64 | Word of B at `rf_word` |
| rf_g_data | input | 64 | Word of G at `rf_word` |
| wr_en | output | 1 | Write strobe of the result word |
| wr_sel | output | 4 | Destination register select |
| wr_data | output | 64 | Result word |
| flag_n | output | 1 | First-active flag |
| flag_z | output | 1 | None-active flag |
| flag_c | output | 1 | Not-last-active flag |
| flag_v | output | 1 | Overflow flag, always 0 |

## Verification
Every op runs on dense pseudo-random operand words, so that each lane function is separated from the other seven. An all-zero governor and an all-ones governor with zero operands isolate the empty-governor flag values and the tail trim. With the all-ones governor, a missing trim would show as set bits above the length and as a wrong not-last-active flag. Destination-equals-source runs check the write ordering. Malformed and flag-select encodings check that nothing is written.

// File: rtl/predlogic_pkg.sv
package predlogic_pkg;
   localparam int WORD_W = 64;
   localparam int SEL_W  = 4;

   localparam logic [7:0] FIX_TOP = 8'h25;
   localparam logic [1:0] FIX_MID = 2'b00;
   localparam logic [1:0] FIX_LOW = 2'b01;

   // {family bit, sub-op pair}
   typedef enum logic [2:0] {
      OP_AND  = 3'b000,
      OP_BIC  = 3'b001,
      OP_EOR  = 3'b010,
      OP_SEL  = 3'b011,
      OP_ORR  = 3'b100,
      OP_ORN  = 3'b101,
      OP_NOR  = 3'b110,
      OP_NAND = 3'b111
   } op_e;

   // one-hot of the highest set bit, zero when none
   function automatic logic [WORD_W-1:0] top_onehot(input logic [WORD_W-1:0] v);
      logic [WORD_W-1:0] r;
      r = '0;
      for (int i = 0; i < WORD_W; i++) begin
         if (v[i]) r = WORD_W'(1) << i;
      end
      return r;
   endfunction
endpackage

// File: rtl/predlogic_decode.sv
module predlogic_decode
   import predlogic_pkg::*;
(
   input  logic [31:0]      insn,
   output op_e              op,
   output logic             set_flags,
   output logic             legal,
   output logic [SEL_W-1:0] d_sel,
   output logic [SEL_W-1:0] a_sel,
   output logic [SEL_W-1:0] b_sel,
   output logic [SEL_W-1:0] g_sel
);
   logic fixed_ok;

   always_comb begin
      fixed_ok  = (insn[31:24] == FIX_TOP) && (insn[21:20] == FIX_MID) &&
                  (insn[15:14] == FIX_LOW);
      op        = op_e'({insn[23], insn[9], insn[4]});
      set_flags = insn[22];
      legal     = fixed_ok && !(set_flags && (op == OP_SEL));
   end

   assign d_sel = insn[3:0];
   assign a_sel = insn[8:5];
   assign g_sel = insn[13:10];
   assign b_sel = insn[19:16];
endmodule

// File: rtl/predlogic_word.sv
module predlogic_word
   import predlogic_pkg::*;
(
   input  op_e               op,
   input  logic [WORD_W-1:0] a,
   input  logic [WORD_W-1:0] b,
   input  logic [WORD_W-1:0] g,
   output logic [WORD_W-1:0] d
);
   always_comb begin
      case (op)
         OP_AND:  d = (a & b) & g;
         OP_BIC:  d = (a & ~b) & g;
         OP_EOR:  d = (a ^ b) & g;
         OP_SEL:  d = (a & g) | (b & ~g);
         OP_ORR:  d = (a | b) & g;
         OP_ORN:  d = (a | ~b) & g;
         OP_NOR:  d = ~(a | b) & g;
         OP_NAND: d = ~(a & b) & g;
         default: d = '0;
      endcase
   end
endmodule

// File: rtl/predlogic_gtrim.sv
module predlogic_gtrim
   import predlogic_pkg::*;
#(
   parameter int PRED_BITS = 80,
   parameter int IDX_W     = 1
)(
   input  logic [IDX_W-1:0]  idx,
   input  logic [WORD_W-1:0] g_raw,
   output logic [WORD_W-1:0] g_eff
);
   localparam int NWORDS = (PRED_BITS + WORD_W - 1) / WORD_W;
   localparam int TAIL   = PRED_BITS % WORD_W;

   generate
      if (TAIL == 0) begin : g_full
         assign g_eff = g_raw;
      end else begin : g_part
         localparam logic [WORD_W-1:0] KEEP = {{(WORD_W-TAIL){1'b0}}, {TAIL{1'b1}}};
         localparam logic [IDX_W-1:0]  LAST = IDX_W'(NWORDS - 1);
         assign g_eff = (idx == LAST) ? (g_raw & KEEP) : g_raw;
      end
   endgenerate
endmodule

// File: rtl/predlogic_flagacc.sv
module predlogic_flagacc
   import predlogic_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              step,
   input  logic [WORD_W-1:0] gw,
   input  logic [WORD_W-1:0] dw,
   output logic              fin_n,
   output logic              fin_z,
   output logic              fin_c
);
   logic seen_q, n_q, c_q, any_q;
   logic seen_d, n_d, c_d, any_d;
   logic g_any, first_b, last_b;
   logic [WORD_W-1:0] low_g, high_g;

   always_comb begin
      g_any   = |gw;
      low_g   = gw & (~gw + WORD_W'(1));
      high_g  = top_onehot(gw);
      first_b = |(dw & low_g);
      last_b  = |(dw & high_g);
      seen_d  = seen_q | g_any;
      n_d     = (!seen_q && g_any) ? first_b : n_q;
      c_d     = g_any ? !last_b : c_q;
      any_d   = any_q | (|dw);
      fin_n   = seen_d ? n_d : 1'b0;
      fin_c   = seen_d ? c_d : 1'b1;
      fin_z   = !any_d;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q <= 1'b0; n_q <= 1'b0; c_q <= 1'b1; any_q <= 1'b0;
      end else if (clear) begin
         seen_q <= 1'b0; n_q <= 1'b0; c_q <= 1'b1; any_q <= 1'b0;
      end else if (step) begin
         seen_q <= seen_d; n_q <= n_d; c_q <= c_d; any_q <= any_d;
      end
   end
endmodule

// File: rtl/predlogic_unit.sv
module predlogic_unit
   import predlogic_pkg::*;
#(
   parameter int PRED_BITS = 80,
   localparam int NWORDS   = (PRED_BITS + WORD_W - 1) / WORD_W,
   localparam int IDX_W    = (NWORDS > 1) ? $clog2(NWORDS) : 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [31:0]       insn,
   output logic              busy,
   output logic              done,
   output logic              illegal,
   output logic [IDX_W-1:0]  rf_word,
   output logic [SEL_W-1:0]  rf_a_sel,
   output logic [SEL_W-1:0]  rf_b_sel,
   output logic [SEL_W-1:0]  rf_g_sel,
   input  logic [WORD_W-1:0] rf_a_data,
   input  logic [WORD_W-1:0] rf_b_data,
   input  logic [WORD_W-1:0] rf_g_data,
   output logic              wr_en,
   output logic [SEL_W-1:0]  wr_sel,
   output logic [WORD_W-1:0] wr_data,
   output logic              flag_n,
   output logic              flag_z,
   output logic              flag_c,
   output logic              flag_v
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NWORDS - 1);

   generate
      if (PRED_BITS < 1 || PRED_BITS > 2048) begin : g_bad_len
         $error("predlogic_unit: PRED_BITS must lie in 1..2048");
      end
   endgenerate

   op_e              dec_op, op_q;
   logic             dec_setf, dec_legal, setf_q;
   logic [SEL_W-1:0] dec_d, dec_a, dec_b, dec_g;
   logic [SEL_W-1:0] d_q, a_q, b_q, g_q;
   logic             run_q, done_q, illegal_q;
   logic [IDX_W-1:0] idx_q;
   logic             fn_q, fz_q, fc_q;
   logic             accept;
   logic [WORD_W-1:0] g_eff, d_word;
   logic             fin_n, fin_z, fin_c;

   predlogic_decode u_dec (
      .insn(insn), .op(dec_op), .set_flags(dec_setf), .legal(dec_legal),
      .d_sel(dec_d), .a_sel(dec_a), .b_sel(dec_b), .g_sel(dec_g)
   );

   predlogic_gtrim #(.PRED_BITS(PRED_BITS), .IDX_W(IDX_W)) u_trim (
      .idx(idx_q), .g_raw(rf_g_data), .g_eff(g_eff)
   );

   predlogic_word u_word (
      .op(op_q), .a(rf_a_data), .b(rf_b_data), .g(g_eff), .d(d_word)
   );

   predlogic_flagacc u_flags (
      .clk(clk), .rst_n(rst_n), .clear(accept), .step(run_q),
      .gw(g_eff), .dw(d_word), .fin_n(fin_n), .fin_z(fin_z), .fin_c(fin_c)
   );

   assign accept = start && !run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q     <= 1'b0;
         done_q    <= 1'b0;
         illegal_q <= 1'b0;
         idx_q     <= '0;
         op_q      <= OP_AND;
         setf_q    <= 1'b0;
         d_q       <= '0;
         a_q       <= '0;
         b_q       <= '0;
         g_q       <= '0;
         fn_q      <= 1'b0;
         fz_q      <= 1'b0;
         fc_q      <= 1'b0;
      end else begin
         done_q    <= 1'b0;
         illegal_q <= 1'b0;
         if (accept) begin
            if (dec_legal) begin
               run_q  <= 1'b1;
               idx_q  <= '0;
               op_q   <= dec_op;
               setf_q <= dec_setf;
               d_q    <= dec_d;
               a_q    <= dec_a;
               b_q    <= dec_b;
               g_q    <= dec_g;
            end else begin
               illegal_q <= 1'b1;
            end
         end else if (run_q) begin
            idx_q <= idx_q + IDX_W'(1);
            if (idx_q == LAST_IDX) begin
               run_q  <= 1'b0;
               done_q <= 1'b1;
               if (setf_q) begin
                  fn_q <= fin_n;
                  fz_q <= fin_z;
                  fc_q <= fin_c;
               end
            end
         end
      end
   end

   assign busy     = run_q;
   assign done     = done_q;
   assign illegal  = illegal_q;
   assign rf_word  = idx_q;
   assign rf_a_sel = a_q;
   assign rf_b_sel = b_q;
   assign rf_g_sel = g_q;
   assign wr_en    = run_q;
   assign wr_sel   = d_q;
   assign wr_data  = d_word;
   assign flag_n   = fn_q;
   assign flag_z   = fz_q;
   assign flag_c   = fc_q;
   assign flag_v   = 1'b0;
endmodule

// File: rtl/predlogic_unit_chk.sv
module predlogic_unit_chk #(
   parameter int NWORDS = 2,
   parameter int IDX_W  = 1
)(
   input logic             clk,
   input logic             rst_n,
   input logic             busy,
   input logic             done,
   input logic             illegal,
   input logic             wr_en,
   input logic [IDX_W-1:0] rf_word,
   input logic             flag_n,
   input logic             flag_z,
   input logic             flag_c
);
   AST_WRITE_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> busy); // R5
   AST_WORD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (int'(rf_word) < NWORDS)); // R5
   AST_WORD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && $past(wr_en)) |-> (rf_word == $past(rf_word) + IDX_W'(1))); // R5
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R5
   AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> (!busy && !wr_en && !done)); // R4
   AST_FLAGS_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable({flag_n, flag_z, flag_c}) |-> done); // R8
endmodule

bind predlogic_unit predlogic_unit_chk #(.NWORDS(NWORDS), .IDX_W(IDX_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .illegal(illegal),
   .wr_en(wr_en), .rf_word(rf_word), .flag_n(flag_n), .flag_z(flag_z),
   .flag_c(flag_c)
);

// File: tb/predlogic_unit_test.sv
`timescale 1ns/1ps
module predlogic_unit_test;
   localparam int PB = 80;
   localparam int NW = 2;
   localparam int TW = NW * 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] insn = '0;
   logic        busy, done, illegal, wr_en;
   logic [0:0]  rf_word;
   logic [3:0]  rf_a_sel, rf_b_sel, rf_g_sel, wr_sel;
   logic [63:0] rf_a_data, rf_b_data, rf_g_data, wr_data;
   logic        flag_n, flag_z, flag_c, flag_v;

   logic [TW-1:0] rf [16];
   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   predlogic_unit #(.PRED_BITS(PB)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .insn(insn), .busy(busy),
      .done(done), .illegal(illegal), .rf_word(rf_word), .rf_a_sel(rf_a_sel),
      .rf_b_sel(rf_b_sel), .rf_g_sel(rf_g_sel), .rf_a_data(rf_a_data),
      .rf_b_data(rf_b_data), .rf_g_data(rf_g_data), .wr_en(wr_en),
      .wr_sel(wr_sel), .wr_data(wr_data), .flag_n(flag_n), .flag_z(flag_z),
      .flag_c(flag_c), .flag_v(flag_v)
   );

   assign rf_a_data = rf[rf_a_sel][rf_word*64 +: 64];
   assign rf_b_data = rf[rf_b_sel][rf_word*64 +: 64];
   assign rf_g_data = rf[rf_g_sel][rf_word*64 +: 64];

   always @(posedge clk) if (wr_en) rf[wr_sel][rf_word*64 +: 64] <= wr_data;

   task automatic chk(input string tag, input logic [TW-1:0] act, input logic [TW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(input logic [1:0] grp, input logic [1:0] sub,
                                      input int d, input int a, input int b, input int g);
      return {8'h25, grp, 2'b00, 4'(b), 2'b01, 4'(g), sub[1], 4'(a), sub[0], 4'(d)};
   endfunction

   function automatic logic mbit(input logic [2:0] op, input logic a, input logic b, input logic g);
      case (op)
         3'b000: return a & b & g;
         3'b001: return a & ~b & g;
         3'b010: return (a ^ b) & g;
         3'b011: return g ? a : b;
         3'b100: return (a | b) & g;
         3'b101: return (a | ~b) & g;
         3'b110: return ~(a | b) & g;
         default: return ~(a & b) & g;
      endcase
   endfunction

   // Runs one legal op and checks result, flags, busy length and done pulse
   task automatic run_op(input logic [1:0] grp, input logic [1:0] sub, input int d,
                         input int a, input int b, input int g, input string tag);
      logic [TW-1:0] va, vb, vg, exp;
      logic [3:0] fprev;
      logic en, ez, ec, gi;
      int first, last, busy_cnt, waited;
      va = rf[a]; vb = rf[b]; vg = rf[g];
      fprev = {flag_n, flag_z, flag_c, flag_v};
      first = -1; last = -1; ez = 1'b1;
      for (int i = 0; i < TW; i++) begin
         gi = (i < PB) ? vg[i] : 1'b0;
         exp[i] = mbit({grp[1], sub}, va[i], vb[i], gi);
         if (gi) begin
            if (first < 0) first = i;
            last = i;
         end
         if (i < PB && exp[i]) ez = 1'b0;
      end
      en = (first >= 0) ? exp[first] : 1'b0;
      ec = (last >= 0) ? !exp[last] : 1'b1;
      @(negedge clk);
      insn = mk(grp, sub, d, a, b, g);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      busy_cnt = 0; waited = 0;
      while (!done && waited < 40) begin
         if (busy) busy_cnt++;
         @(negedge clk);
         waited++;
      end
      chk({tag, " R5 done seen"}, TW'(done), TW'(1));
      chk({tag, " R5 busy cycles"}, TW'(busy_cnt), TW'(NW));
      chk({tag, " result"}, rf[d], exp);
      if (grp[0]) chk({tag, " R6 flags"}, TW'({flag_n, flag_z, flag_c, flag_v}), TW'({en, ez, ec, 1'b0}));
      else        chk({tag, " R8 flags kept"}, TW'({flag_n, flag_z, flag_c, flag_v}), TW'(fprev));
      @(negedge clk);
      chk({tag, " R5 done one cycle"}, TW'(done), TW'(0));
   endtask

   task automatic t_reset;
      chk("R11 reset outputs", TW'({busy, done, illegal, wr_en, flag_n, flag_z, flag_c, flag_v}), '0);
   endtask

   task automatic t_plain_ops;
      for (int k = 0; k < 8; k++) begin
         run_op({k[2], 1'b0}, k[1:0], 4 + k, 1, 2, 3, (k == 3) ? "R2 R3 select" : "R1 R3 zeroing op");
      end
      run_op(2'b10, 2'b01, 7, 2, 1, 13, "R1 R3 swapped fields");
   endtask

   task automatic t_flag_ops;
      for (int k = 0; k < 8; k++) begin
         if (k != 3) run_op({k[2], 1'b1}, k[1:0], 12, 1, 2, 3, "R6 flag op");
      end
      run_op(2'b11, 2'b10, 12, 13, 14, 15, "R6 flag op dense");
      run_op(2'b00, 2'b00, 8, 1, 2, 13, "R8 plain after flag op");
   endtask

   task automatic t_illegal(input logic [31:0] bad, input int d, input string tag);
      logic [TW-1:0] keep;
      logic [3:0] fprev;
      int wrote;
      keep = rf[d];
      fprev = {flag_n, flag_z, flag_c, flag_v};
      @(negedge clk);
      insn = bad; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk({tag, " R4 illegal pulse"}, TW'({illegal, busy, done}), TW'(3'b100));
      wrote = 0;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         if (wr_en || busy || done || illegal) wrote++;
      end
      chk({tag, " R4 stays quiet"}, TW'(wrote), '0);
      chk({tag, " R4 dest unchanged"}, rf[d], keep);
      chk({tag, " R4 flags unchanged"}, TW'({flag_n, flag_z, flag_c, flag_v}), TW'(fprev));
   endtask

   task automatic t_empty_gov;
      run_op(2'b01, 2'b00, 9, 1, 2, 0, "R7 empty governor");
      chk("R7 empty governor flag values", TW'({flag_n, flag_z, flag_c}), TW'(3'b011));
   endtask

   task automatic t_tail;
      // NOR of zero operands under all-ones governor: ones up to bit PB-1 only
      run_op(2'b11, 2'b10, 10, 0, 0, 15, "R9 tail trim");
      chk("R9 upper bits zero", rf[10] >> PB, '0);
      chk("R9 last lane inside length", TW'({flag_n, flag_z, flag_c}), TW'(3'b100));
   endtask

   task automatic t_alias;
      rf[5] = rf[13];
      run_op(2'b00, 2'b10, 5, 5, 2, 3, "R10 dest aliases A");
      rf[6] = rf[14];
      run_op(2'b10, 2'b11, 6, 1, 6, 6, "R10 dest aliases B and G");
   endtask

   task automatic t_start_while_busy;
      logic [TW-1:0] keep;
      int dones;
      keep = rf[11];
      @(negedge clk);
      insn = mk(2'b00, 2'b00, 8, 13, 14, 15); start = 1'b1;
      @(negedge clk);
      insn = mk(2'b10, 2'b00, 11, 1, 2, 15);
      @(negedge clk);
      start = 1'b0;
      dones = 0;
      for (int i = 0; i < 6; i++) begin
         if (done) dones++;
         @(negedge clk);
      end
      chk("R5 start during busy ignored", rf[11], keep);
      chk("R5 single done", TW'(dones), TW'(1));
   endtask

   initial begin
      #(8 * 20000);
      errors++;
      $display("FAIL R5 watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < 16; i++) begin
         rf[i] = {64'(i + 3) * 64'h9E3779B97F4A7C15 ^ 64'h0123456789ABCDEF,
                  64'(i + 7) * 64'hC2B2AE3D27D4EB4F};
      end
      rf[0]  = '0;
      rf[15] = '1;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_plain_ops();
      t_flag_ops();
      t_illegal(mk(2'b01, 2'b11, 4, 1, 2, 3), 4, "flag select");
      t_illegal(mk(2'b00, 2'b00, 4, 1, 2, 3) ^ 32'h0010_0000, 4, "bad fixed bits");
      t_empty_gov();
      t_tail();
      t_alias();
      t_start_while_busy();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule